// File: doc/BRIEF.md
# CAN Controller Host Register and Interrupt Unit

This block is the byte-wide host-side register file of a CAN controller running in its extended register layout. A host reads and writes a 32-byte window with one address, one write strobe and one read strobe. The block holds the mode, status, interrupt-flag, interrupt-enable and clock-divider registers, and it drives a level interrupt. It turns command writes into single-cycle strobes for the transmit engine, the receive buffer and the overrun logic. It also emits a one-cycle strobe that tells the acceptance filter to reload when the controller leaves reset mode.

Offsets 16 to 28 form a window whose meaning depends on the reset-mode bit. In reset mode, offsets 16 to 23 hold the eight acceptance code/mask bytes. In operating mode, writes to the window fill a 13-byte transmit buffer, and reads return bytes of an external receive buffer, addressed through a window index output. Two input pulses report that a frame was stored and that a frame was lost to overrun. The block counts pending messages so that the receive interrupt bit can re-assert after a clearing read.

Top module: `can_host_regs`

## Requirements
- R1: While reset is held, and after it is released, the mode register reads 0x01, status reads 0x3C, interrupt flags read 0x00, interrupt enable reads 0x00 and clock divider reads 0x00. The interrupt output is low, the acceptance bytes are zero and no strobe is active.
- R2: Writes to the mode register (offset 0) keep bits 4:0 and store bits 7:5 as zero. Bit 0 is the reset-mode bit.
- R3: A mode write that moves bit 0 from 1 to 0 raises `load_filt_o` for one cycle, in the cycle after the write, and clears the pending-message counter.
- R4: A read of the interrupt register (offset 3) returns the flags held before the read and then clears them. Bit 0 (receive) is set again in the same cycle when the pending-message counter is nonzero.
- R5: `irq_o` is high exactly when interrupt enable (offset 4) ANDed with the interrupt flags is nonzero, and it follows every change of either.
- R6: A command write (offset 1) with bit 0 set pulses `tx_req_o`, sets status bits 2 and 3, clears status bit 5 and sets interrupt bit 1.
- R7: Command bit 2, when the counter is nonzero, pulses `rel_o` and decrements the counter. When the count reaches zero it clears status bit 0 and interrupt bit 0. When the counter is zero, command bit 2 has no effect.
- R8: Command bit 3 pulses `clr_ovr_o` and clears status bit 1 and interrupt bit 3.
- R9: `rx_store_i` increments the counter (saturating) and sets status bit 0 and interrupt bit 0. `rx_ovr_i` sets status bit 1 and interrupt bit 3. These events are applied after a same-cycle read-clear or command.
- R10: A write to offset 16 sets status bit 5 in either mode. In reset mode, writes to offsets 16 to 23 load acceptance byte (offset-16), which appears on `acc_o[8k+7:8k]` and reads back. Writes to offsets 24 to 28 are ignored, and those offsets read 0x00.
- R11: In operating mode, writes to offsets 16 to 28 load transmit-buffer byte (offset-16) without touching the acceptance bytes. Reads there return `rx_data_i`, with `rx_idx_o` equal to offset-16.
- R12: The command register and offsets 5 to 15 read 0x00. Offsets 29 and 30 read 0xFF. Offset 31 reads back the clock divider. Writes to status (offset 2) and interrupt (offset 3) have no effect.
- R13: Several command bits in one write are all processed in the order transmit, release, clear-overrun.
- R14: Read data appears on `rdata_o` one cycle after `rd_en_i` and holds until the next read. The transmit buffer read port also has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 5 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| rx_store_i | input | 1 | Pulse: a received frame was stored |
| rx_ovr_i | input | 1 | Pulse: a received frame was lost to overrun |
| rx_data_i | input | 8 | Receive-buffer byte selected by `rx_idx_o` |
| rx_idx_o | output | 4 | Receive window index (offset-16) |
| txb_raddr_i | input | 4 | Transmit buffer read address |
| txb_rdata_o | output | 8 | Transmit buffer read data |
| acc_o | output | 64 | Acceptance code/mask bytes 0..7 |
| tx_req_o | output | 1 | Transmit request strobe |
| rel_o | output | 1 | Receive buffer release strobe |
| clr_ovr_o | output | 1 | Clear overrun strobe |
| load_filt_o | output | 1 | Filter reload strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
The directed part first walks the register map with reads only. It then drives the window in both modes. This separates a decode fault (wrong constant or wrong region) from a steering fault (a byte landing in the acceptance bank instead of the transmit buffer). Receive pulses are stacked before clearing reads, and release commands are issued past zero. These patterns tell the re-assert rule of the interrupt read apart from a plain clear, and a guarded decrement from an unguarded one. Combined command bytes and coincident rx events expose ordering mistakes. A long seeded random mix of reads, writes and event pulses then compares every read, the interrupt level and all strobes with a model built from the requirements.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;
  localparam int A_MODE  = 0;
  localparam int A_CMD   = 1;
  localparam int A_STAT  = 2;
  localparam int A_INTR  = 3;
  localparam int A_IEN   = 4;
  localparam int A_ZLO   = 5;
  localparam int A_CDIV  = 31;

  localparam int MODE_BITS = 5;
  localparam int MD_RST    = 0;

  localparam int CMD_TX   = 0;
  localparam int CMD_REL  = 2;
  localparam int CMD_CLRO = 3;

  localparam int ST_RXF  = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_TXF  = 2;
  localparam int ST_TXD  = 3;
  localparam int ST_TXB  = 5;

  localparam int IR_RX  = 0;
  localparam int IR_TX  = 1;
  localparam int IR_OVR = 3;

  localparam logic [7:0] MODE_RST_VAL = 8'h01;
  localparam logic [7:0] STAT_RST_VAL = 8'h3C;

  typedef enum logic [3:0] {
    RG_MODE, RG_CMD, RG_STAT, RG_INTR, RG_IEN,
    RG_ZERO, RG_WIN, RG_CDIV, RG_NONE
  } reg_sel_e;
endpackage

// File: rtl/creg_decode.sv
module creg_decode
  import can_regs_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WIN_BASE = 16,
  parameter int WIN_LEN  = 13,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  win_idx
);
  localparam int AW = ADDR_W + 1;
  localparam logic [AW-1:0] WLO = AW'(WIN_BASE);
  localparam logic [AW-1:0] WHI = AW'(WIN_BASE + WIN_LEN);
  localparam logic [AW-1:0] ZLO = AW'(A_ZLO);

  logic [AW-1:0] a_ext;

  always_comb begin
    a_ext   = {1'b0, addr};
    win_idx = IDX_W'(a_ext - WLO);
    if (a_ext == AW'(A_MODE))               sel = RG_MODE;
    else if (a_ext == AW'(A_CMD))           sel = RG_CMD;
    else if (a_ext == AW'(A_STAT))          sel = RG_STAT;
    else if (a_ext == AW'(A_INTR))          sel = RG_INTR;
    else if (a_ext == AW'(A_IEN))           sel = RG_IEN;
    else if (a_ext >= WLO && a_ext < WHI)   sel = RG_WIN;
    else if (a_ext == AW'(A_CDIV))          sel = RG_CDIV;
    else if (a_ext >= ZLO && a_ext < WLO)   sel = RG_ZERO;
    else                                    sel = RG_NONE;
  end
endmodule

// File: rtl/creg_accbank.sv
module creg_accbank #(
  parameter int NBYTES = 8,
  parameter int IDX_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    idx,
  input  logic [7:0]          wdata,
  output logic [7:0]          rd_byte,
  output logic [NBYTES*8-1:0] bytes_o
);
  logic [7:0] bank [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    localparam logic [IDX_W-1:0] KI = IDX_W'(k);
    always_ff @(posedge clk) begin
      if (rst)                   bank[k] <= '0;
      else if (we && idx == KI)  bank[k] <= wdata;
    end
    assign bytes_o[k*8 +: 8] = bank[k];
  end

  assign rd_byte = bank[idx];
endmodule

// File: rtl/creg_txbuf.sv
module creg_txbuf #(
  parameter int DEPTH = 13,
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr <= LAST) mem[waddr] <= wdata;
    rdata <= (raddr <= LAST) ? mem[raddr] : '0;
  end
endmodule

// File: rtl/can_host_regs.sv
module can_host_regs
  import can_regs_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WIN_BASE = 16,
  parameter int WIN_LEN  = 13,
  parameter int ACC_LEN  = 8,
  parameter int CNT_W    = 7,
  parameter int IDX_W    = $clog2(WIN_LEN),
  parameter int ACC_IW   = $clog2(ACC_LEN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic                 rx_store_i,
  input  logic                 rx_ovr_i,
  input  logic [7:0]           rx_data_i,
  output logic [IDX_W-1:0]     rx_idx_o,
  input  logic [IDX_W-1:0]     txb_raddr_i,
  output logic [7:0]           txb_rdata_o,
  output logic [ACC_LEN*8-1:0] acc_o,
  output logic                 tx_req_o,
  output logic                 rel_o,
  output logic                 clr_ovr_o,
  output logic                 load_filt_o,
  output logic                 irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] ACC_END = IDX_W'(ACC_LEN);

  reg_sel_e         sel;
  logic [IDX_W-1:0] win_idx;
  logic             in_acc;
  logic [7:0]       acc_rd;

  logic [7:0] mode_q, stat_q, intr_q, ien_q, cdiv_q;
  logic [7:0] mode_d, stat_d, intr_d, ien_d, cdiv_d;
  logic [CNT_W-1:0] msg_cnt_q, msg_cnt_d;
  logic tx_p, rel_p, clro_p, lf_p;
  logic acc_we, txb_we;
  logic [7:0] rd_d;

  creg_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LEN(WIN_LEN), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr_i), .sel(sel), .win_idx(win_idx)
  );

  assign in_acc   = (win_idx < ACC_END);
  assign rx_idx_o = win_idx;
  assign acc_we   = wr_en_i && sel == RG_WIN && mode_q[MD_RST] && in_acc;
  assign txb_we   = wr_en_i && sel == RG_WIN && !mode_q[MD_RST];

  creg_accbank #(.NBYTES(ACC_LEN), .IDX_W(ACC_IW)) u_acc (
    .clk(clk), .rst(rst), .we(acc_we), .idx(win_idx[ACC_IW-1:0]),
    .wdata(wdata_i), .rd_byte(acc_rd), .bytes_o(acc_o)
  );

  creg_txbuf #(.DEPTH(WIN_LEN), .DW(8), .IDX_W(IDX_W)) u_txb (
    .clk(clk), .we(txb_we), .waddr(win_idx), .wdata(wdata_i),
    .raddr(txb_raddr_i), .rdata(txb_rdata_o)
  );

  // Next-state: read-clear, then command/write effects, then rx events.
  always_comb begin
    mode_d    = mode_q;
    stat_d    = stat_q;
    intr_d    = intr_q;
    ien_d     = ien_q;
    cdiv_d    = cdiv_q;
    msg_cnt_d = msg_cnt_q;
    tx_p      = 1'b0;
    rel_p     = 1'b0;
    clro_p    = 1'b0;
    lf_p      = 1'b0;

    if (rd_en_i && sel == RG_INTR) begin
      intr_d = '0;
      if (msg_cnt_q != '0) intr_d[IR_RX] = 1'b1;
    end

    if (wr_en_i) begin
      case (sel)
        RG_MODE: begin
          mode_d = {{(8-MODE_BITS){1'b0}}, wdata_i[MODE_BITS-1:0]};
          if (mode_q[MD_RST] && !wdata_i[MD_RST]) begin
            lf_p      = 1'b1;
            msg_cnt_d = '0;
          end
        end
        RG_CMD: begin
          if (wdata_i[CMD_TX]) begin
            tx_p           = 1'b1;
            stat_d[ST_TXF] = 1'b1;
            stat_d[ST_TXD] = 1'b1;
            stat_d[ST_TXB] = 1'b0;
            intr_d[IR_TX]  = 1'b1;
          end
          if (wdata_i[CMD_REL] && msg_cnt_d != '0) begin
            rel_p     = 1'b1;
            msg_cnt_d = msg_cnt_d - 1'b1;
            if (msg_cnt_d == '0) begin
              stat_d[ST_RXF] = 1'b0;
              intr_d[IR_RX]  = 1'b0;
            end
          end
          if (wdata_i[CMD_CLRO]) begin
            clro_p         = 1'b1;
            stat_d[ST_OVR] = 1'b0;
            intr_d[IR_OVR] = 1'b0;
          end
        end
        RG_IEN:  ien_d  = wdata_i;
        RG_CDIV: cdiv_d = wdata_i;
        RG_WIN:  if (win_idx == '0) stat_d[ST_TXB] = 1'b1;
        default: ;
      endcase
    end

    if (rx_store_i) begin
      if (msg_cnt_d != CNT_MAX) msg_cnt_d = msg_cnt_d + 1'b1;
      stat_d[ST_RXF] = 1'b1;
      intr_d[IR_RX]  = 1'b1;
    end
    if (rx_ovr_i) begin
      stat_d[ST_OVR] = 1'b1;
      intr_d[IR_OVR] = 1'b1;
    end
  end

  always_comb begin
    case (sel)
      RG_MODE: rd_d = mode_q;
      RG_STAT: rd_d = stat_q;
      RG_INTR: rd_d = intr_q;
      RG_IEN:  rd_d = ien_q;
      RG_CDIV: rd_d = cdiv_q;
      RG_WIN:  rd_d = mode_q[MD_RST] ? (in_acc ? acc_rd : 8'h00) : rx_data_i;
      RG_NONE: rd_d = 8'hFF;
      default: rd_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_RST_VAL;
      stat_q      <= STAT_RST_VAL;
      intr_q      <= '0;
      ien_q       <= '0;
      cdiv_q      <= '0;
      msg_cnt_q   <= '0;
      rdata_o     <= '0;
      tx_req_o    <= 1'b0;
      rel_o       <= 1'b0;
      clr_ovr_o   <= 1'b0;
      load_filt_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      stat_q      <= stat_d;
      intr_q      <= intr_d;
      ien_q       <= ien_d;
      cdiv_q      <= cdiv_d;
      msg_cnt_q   <= msg_cnt_d;
      if (rd_en_i) rdata_o <= rd_d;
      tx_req_o    <= tx_p;
      rel_o       <= rel_p;
      clr_ovr_o   <= clro_p;
      load_filt_o <= lf_p;
      irq_o       <= |(ien_d & intr_d);
    end
  end
endmodule

// File: rtl/can_host_regs_chk.sv
module can_host_regs_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic [7:0]       ien_q,
  input logic [7:0]       intr_q,
  input logic [7:0]       stat_q,
  input logic [7:0]       mode_q,
  input logic [CNT_W-1:0] msg_cnt_q,
  input logic             tx_req_o,
  input logic             rel_o,
  input logic             clr_ovr_o,
  input logic             load_filt_o,
  input logic             rx_ovr_i
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(ien_q & intr_q)); // R5

  AST_TX_STATUS: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> (stat_q[3:2] == 2'b11 && !stat_q[5] && intr_q[1])); // R6

  AST_REL_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    rel_o |-> $past(msg_cnt_q) != '0); // R7

  AST_LOAD_FILT: assert property (@(posedge clk) disable iff (rst)
    load_filt_o |-> (!mode_q[0] && $past(mode_q[0]))); // R3

  AST_CLR_OVR: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr_o && !$past(rx_ovr_i)) |-> (!stat_q[1] && !intr_q[3])); // R8
endmodule

bind can_host_regs can_host_regs_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_can_host_regs.sv
`timescale 1ns/1ps
module test_can_host_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en_i = 0, rd_en_i = 0, rx_store_i = 0, rx_ovr_i = 0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, rx_data_i, txb_rdata_o;
  logic [3:0] rx_idx_o;
  logic [3:0] txb_raddr_i = '0;
  logic [63:0] acc_o;
  logic tx_req_o, rel_o, clr_ovr_o, load_filt_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_mode, m_stat, m_int, m_ien, m_cdiv;
  logic [6:0] m_cnt;
  logic [7:0] m_acc [8];
  logic [7:0] m_txb [13];

  always #2 clk = ~clk;
  assign rx_data_i = {4'hA, rx_idx_o};

  can_host_regs i_can_host_regs (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [4:0] a);
    if (a == 0) return m_mode;
    if (a == 2) return m_stat;
    if (a == 3) return m_int;
    if (a == 4) return m_ien;
    if (a == 31) return m_cdiv;
    if (a >= 16 && a <= 28) begin
      if (m_mode[0]) return (a < 24) ? m_acc[a-16] : 8'h00;
      return {4'hA, 4'(a - 16)};
    end
    if (a == 29 || a == 30) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic step(input logic w, input logic r, input logic [4:0] a,
                      input logic [7:0] d, input logic rs, input logic ro,
                      input string tag);
    logic [7:0] e_rd;
    logic [3:0] e_p;
    @(negedge clk);
    wr_en_i = w; rd_en_i = r; addr_i = a; wdata_i = d;
    rx_store_i = rs; rx_ovr_i = ro;
    e_rd = exp_read(a);
    e_p = '0;
    if (r && a == 3) begin
      m_int = '0;
      if (m_cnt != 0) m_int[0] = 1'b1;
    end
    if (w) begin
      if (a == 0) begin
        if (m_mode[0] && !d[0]) begin e_p[3] = 1'b1; m_cnt = '0; end
        m_mode = d & 8'h1F;
      end else if (a == 1) begin
        if (d[0]) begin e_p[0] = 1'b1; m_stat[3:2] = 2'b11; m_stat[5] = 1'b0; m_int[1] = 1'b1; end
        if (d[2] && m_cnt != 0) begin
          e_p[1] = 1'b1; m_cnt = m_cnt - 1'b1;
          if (m_cnt == 0) begin m_stat[0] = 1'b0; m_int[0] = 1'b0; end
        end
        if (d[3]) begin e_p[2] = 1'b1; m_stat[1] = 1'b0; m_int[3] = 1'b0; end
      end else if (a == 4) m_ien = d;
      else if (a == 31) m_cdiv = d;
      else if (a >= 16 && a <= 28) begin
        if (a == 16) m_stat[5] = 1'b1;
        if (m_mode[0]) begin
          if (a < 24) m_acc[a-16] = d;
        end else m_txb[a-16] = d;
      end
    end
    if (rs) begin
      if (m_cnt != 7'h7F) m_cnt = m_cnt + 1'b1;
      m_stat[0] = 1'b1; m_int[0] = 1'b1;
    end
    if (ro) begin m_stat[1] = 1'b1; m_int[3] = 1'b1; end
    @(posedge clk); #1;
    if (r) chk({tag, " rdata"}, rdata_o, e_rd);
    chk({"R5 irq (", tag, ")"}, irq_o, |(m_ien & m_int));
    chk({tag, " strobes"}, {load_filt_o, clr_ovr_o, rel_o, tx_req_o}, e_p);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic chk_txb(input int idx, input string tag);
    @(negedge clk);
    wr_en_i = 0; rd_en_i = 0; rx_store_i = 0; rx_ovr_i = 0;
    txb_raddr_i = 4'(idx);
    @(posedge clk); #1;
    chk(tag, txb_rdata_o, m_txb[idx]);
  endtask

  function automatic logic [63:0] acc_pack();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_acc[k];
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mode = 8'h01; m_stat = 8'h3C; m_int = 0; m_ien = 0; m_cdiv = 0; m_cnt = 0;
    for (int k = 0; k < 8; k++) m_acc[k] = 0;
    for (int k = 0; k < 13; k++) m_txb[k] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1: values under reset
    chk("R1 irq in reset", irq_o, 1'b0);
    chk("R1 strobes in reset", {load_filt_o, clr_ovr_o, rel_o, tx_req_o}, 4'h0);
    chk("R1 rdata in reset", rdata_o, 8'h00);
    @(negedge clk); rst = 1'b0;
    rd(0, "R1 mode"); rd(2, "R1 status"); rd(3, "R1 intr");
    rd(4, "R1 ien"); rd(31, "R1 clkdiv");
    chk("R1 acc", acc_o, 64'h0);
    // R2: mode width
    wr(0, 8'hFF, "R2"); rd(0, "R2 mode low five bits");
    wr(0, 8'h01, "R2");
    // R10: reset-mode window
    for (int k = 0; k < 8; k++) wr(5'(16 + k), 8'(8'h31 * (k + 1)), "R10");
    wr(24, 8'h5A, "R10 ignored"); wr(28, 8'hA5, "R10 ignored");
    for (int k = 16; k <= 28; k++) rd(5'(k), "R10 readback");
    rd(2, "R10 status bit5");
    chk("R10 acc bytes", acc_o, acc_pack());
    wr(4, 8'h0B, "R5");
    // R3: leave reset mode
    wr(0, 8'h00, "R3 leave reset");
    // R11: operating-mode window
    for (int k = 0; k < 13; k++) wr(5'(16 + k), 8'(8'hC0 + k), "R11");
    for (int k = 0; k < 13; k++) chk_txb(k, "R11 txb");
    for (int k = 16; k <= 28; k++) rd(5'(k), "R11 rx window");
    chk("R11 acc unchanged", acc_o, acc_pack());
    chk_txb(12, "R14 txb read latency");
    // R6
    wr(1, 8'h01, "R6 tx"); rd(2, "R6 status"); rd(3, "R4 intr after tx");
    // R9, R4
    step(0, 0, 0, 0, 1, 0, "R9 rx store");
    step(0, 0, 0, 0, 1, 0, "R9 rx store");
    rd(3, "R4 intr read"); rd(3, "R4 rx bit reasserted");
    // R7
    wr(1, 8'h04, "R7 release"); rd(2, "R7 status");
    wr(1, 8'h04, "R7 release last"); rd(2, "R7 status empty"); rd(3, "R7 intr");
    wr(1, 8'h04, "R7 release empty"); rd(2, "R7 no effect");
    // R8
    step(0, 0, 0, 0, 0, 1, "R9 overrun"); rd(2, "R9 status");
    wr(1, 8'h08, "R8 clear overrun"); rd(2, "R8 status"); rd(3, "R8 intr");
    // R13: combined commands, coincident event
    step(0, 0, 0, 0, 1, 1, "R9 both events");
    wr(1, 8'h0D, "R13 combined"); rd(2, "R13 status"); rd(3, "R13 intr");
    step(1, 0, 1, 8'h0C, 1, 1, "R13 with events"); rd(2, "R13 status"); rd(3, "R13 intr");
    // R12: read map and ignored writes
    rd(1, "R12 cmd"); for (int k = 5; k < 16; k++) rd(5'(k), "R12 zero");
    rd(29, "R12 unmapped"); rd(30, "R12 unmapped");
    wr(31, 8'h87, "R12"); rd(31, "R12 clkdiv");
    wr(2, 8'h00, "R12"); rd(2, "R12 status write ignored");
    wr(3, 8'hFF, "R12"); rd(3, "R12 intr write ignored");
    // R3: count cleared when leaving reset mode
    step(0, 0, 0, 0, 1, 0, "R9"); wr(0, 8'h01, "R3 enter reset");
    wr(0, 8'h08, "R3 leave reset"); rd(3, "R3 intr"); rd(3, "R3 count cleared");
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] a;
      logic [7:0] d;
      logic w, r;
      a = ($urandom % 3 == 0) ? 5'(16 + $urandom % 13) : 5'($urandom % 32);
      d = 8'($urandom);
      if (a == 0 && ($urandom % 2 == 0)) d[0] = ~m_mode[0];
      w = ($urandom % 2) == 1;
      r = ($urandom % 2) == 1;
      step(w, r, a, d, ($urandom % 4) == 0, ($urandom % 8) == 0, "R9 random");
    end
    chk("R10 acc after random", acc_o, acc_pack());
    for (int k = 0; k < 13; k++) chk_txb(k, "R11 txb after random");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule